// File: doc/BRIEF.md
# DMA Burst Length Sequencer

This block takes one DMA buffer transfer, given as a start byte address and a length in 32-bit beats, and breaks it into a series of bus bursts. Each burst is presented as a start address and a beat count through a valid/ready handshake. A one-cycle done pulse marks the end of the transfer. The bus protocol signalling, the data path and descriptor processing are handled by neighbouring logic.

The burst size comes from one of two 6-bit length fields. When per-direction lengths are enabled, a receive transfer uses the receive field and a transmit transfer uses the transmit field. Otherwise the transmit field serves both directions. A times-eight control multiplies the selected value by 8. An alignment mode trims bursts so that they fall on boundaries of the effective burst size. In this mode the fixed-burst setting chooses between two schemes: trimming only the opening burst, or splitting the transfer into naturally aligned power-of-two bursts.

A transfer is launched by pulsing `xfer_start` while the block is idle. All configuration inputs are sampled on that cycle.

Top module: `dma_burst_seq`

## Requirements
- R1: The selected length field is `rx_len_fld` when `split_len_en`=1 and `xfer_rx`=1. In every other case it is `tx_len_fld`.
- R2: The effective burst length E is the selected field value, multiplied by 8 when `len_x8`=1. E can therefore be 1 to 32, or 8 to 256, and no burst has more than E beats.
- R3: A selected field value other than 1, 2, 4, 8, 16 or 32 (0 included) makes `cfg_err` high for exactly one cycle, in the cycle after the start. No burst is issued and no done pulse follows.
- R4: With `align_en`=0, every burst carries E beats except the final one, which carries the remaining beats. Each burst starts at the previous burst's address plus 4 × its beat count.
- R5: With `align_en`=1 and `fixed_burst_en`=0, each burst carries min(remaining, E − ((address/4) mod E)) beats. This trims the first burst so that every later burst starts on a multiple of 4·E bytes.
- R6: With `align_en`=1 and `fixed_burst_en`=1, each burst size is the largest power of two N that satisfies all of: N ≤ E, N ≤ remaining beats, and (address/4) is a multiple of N.
- R7: While `burst_valid`=1 and `burst_ready`=0, `burst_valid`, `burst_addr`, `burst_beats` and `burst_last` hold their values.
- R8: `burst_last` is high on the final burst. `xfer_done` pulses for one cycle, in the cycle after the final burst is accepted, and is never high together with `burst_valid`.
- R9: A start with `xfer_beats`=0 issues no burst and pulses `xfer_done` in the cycle after the start.
- R10: A start pulse while a transfer is active (`busy`=1) is ignored, and the running transfer is not disturbed.
- R11: The first burst appears in the cycle after the start. Changes to the configuration inputs after the start do not affect the running transfer.
- R12: After reset, `burst_valid`, `xfer_done`, `cfg_err` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start pulse, accepted only when idle |
| xfer_addr | input | 32 | Buffer start byte address |
| xfer_beats | input | 16 | Transfer length in beats |
| xfer_rx | input | 1 | 1 = receive direction, 0 = transmit |
| fixed_burst_en | input | 1 | Fixed-burst scheme for alignment mode |
| align_en | input | 1 | Address-aligned burst mode |
| split_len_en | input | 1 | Per-direction length fields |
| tx_len_fld | input | 6 | Transmit (or shared) burst length |
| rx_len_fld | input | 6 | Receive burst length |
| len_x8 | input | 1 | Multiply the selected length by 8 |
| burst_valid | output | 1 | Burst descriptor valid |
| burst_ready | input | 1 | Downstream accepts the descriptor |
| burst_addr | output | 32 | Burst start byte address |
| burst_beats | output | 9 | Burst beat count |
| burst_last | output | 1 | Final burst of the transfer |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | One-cycle invalid-length pulse |
| busy | output | 1 | Transfer in progress |

## Verification
Splitting is tried with an aligned start and no alignment mode, which separates full bursts from the short tail. Starts that are not aligned are tried in both alignment schemes: a trimmed first burst followed by full ones shows the non-fixed scheme, and a ladder of growing then shrinking power-of-two sizes shows the fixed scheme. Direction and per-direction combinations are run with distinct transmit and receive field values, so that picking the wrong field changes the sizes. Large transfers with the times-eight control reach the 256-beat limit, and stalls on ready, restarts while busy and configuration changes after the start show that accepted state does not move.

// File: rtl/dma_burst_seq_pkg.sv
package dma_burst_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dbs_rst_sync.sv
module dbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dbs_len_select.sv
module dbs_len_select #(
  parameter int FLD_W = 6,
  parameter int MUL_LG = 3,
  localparam int EFF_W = FLD_W + MUL_LG
) (
  input  logic [FLD_W-1:0] tx_fld,
  input  logic [FLD_W-1:0] rx_fld,
  input  logic             split_en,
  input  logic             dir_rx,
  input  logic             mul_en,
  output logic [EFF_W-1:0] eff_len,
  output logic             fld_bad
);
  logic [FLD_W-1:0] pick;

  always_comb begin
    pick    = (split_en && dir_rx) ? rx_fld : tx_fld;
    fld_bad = !$onehot(pick);
    if (mul_en) eff_len = {pick, {MUL_LG{1'b0}}};
    else        eff_len = {{MUL_LG{1'b0}}, pick};
  end
endmodule

// File: rtl/dbs_burst_sizer.sv
module dbs_burst_sizer #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter int EFF_W = 9,
  parameter int BEAT_LG = 2
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  rem_beats,
  input  logic [EFF_W-1:0]  eff_len,
  input  logic              align_en,
  input  logic              fixed_en,
  output logic [EFF_W-1:0]  size
);
  logic [EFF_W-1:0] beat_idx;
  logic [EFF_W-1:0] offset;
  logic [EFF_W-1:0] rem_cap;
  logic [EFF_W-1:0] natural;
  logic [EFF_W-1:0] nat_low;
  logic [EFF_W-1:0] rem_pow2;
  logic [EFF_W-1:0] trim_lim;

  assign beat_idx = cur_addr[EFF_W+BEAT_LG-1:BEAT_LG];
  assign offset   = beat_idx & (eff_len - EFF_W'(1));
  assign rem_cap  = (rem_beats >= LEN_W'(eff_len)) ? eff_len : rem_beats[EFF_W-1:0];
  assign natural  = beat_idx | eff_len;
  assign nat_low  = natural & (~natural + EFF_W'(1));
  assign trim_lim = eff_len - offset;

  // highest power of two not above the capped remainder
  always_comb begin
    rem_pow2 = '0;
    for (int i = 0; i < EFF_W; i++) begin
      if (rem_cap[i]) rem_pow2 = EFF_W'(1) << i;
    end
  end

  always_comb begin
    if (!align_en) begin
      size = rem_cap;
    end else if (!fixed_en) begin
      size = (trim_lim < rem_cap) ? trim_lim : rem_cap;
    end else begin
      size = (nat_low < rem_pow2) ? nat_low : rem_pow2;
    end
  end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter int FLD_W = 6,
  parameter int MUL_LG = 3,
  parameter int BEAT_LG = 2,
  localparam int EFF_W = FLD_W + MUL_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [LEN_W-1:0]  xfer_beats,
  input  logic              xfer_rx,
  input  logic              fixed_burst_en,
  input  logic              align_en,
  input  logic              split_len_en,
  input  logic [FLD_W-1:0]  tx_len_fld,
  input  logic [FLD_W-1:0]  rx_len_fld,
  input  logic              len_x8,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [EFF_W-1:0]  burst_beats,
  output logic              burst_last,
  output logic              xfer_done,
  output logic              cfg_err,
  output logic              busy
);
  import dma_burst_seq_pkg::*;

  logic rst_ni;
  seq_state_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [EFF_W-1:0]  eff_q, eff_d;
  logic align_q, align_d, fixed_q, fixed_d;
  logic done_q, done_d, err_q, err_d;
  logic desc_en;
  logic [EFF_W-1:0] sel_eff;
  logic sel_bad;
  logic [EFF_W-1:0] size;
  logic take;

  dbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  dbs_len_select #(.FLD_W(FLD_W), .MUL_LG(MUL_LG)) u_sel (
    .tx_fld(tx_len_fld), .rx_fld(rx_len_fld), .split_en(split_len_en),
    .dir_rx(xfer_rx), .mul_en(len_x8), .eff_len(sel_eff), .fld_bad(sel_bad)
  );

  dbs_burst_sizer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .EFF_W(EFF_W), .BEAT_LG(BEAT_LG)) u_size (
    .cur_addr(addr_q), .rem_beats(rem_q), .eff_len(eff_q),
    .align_en(align_q), .fixed_en(fixed_q), .size(size)
  );

  assign burst_valid = (st_q == SEQ_RUN);
  assign busy        = (st_q == SEQ_RUN);
  assign burst_addr  = addr_q;
  assign burst_beats = size;
  assign burst_last  = (LEN_W'(size) == rem_q);
  assign xfer_done   = done_q;
  assign cfg_err     = err_q;
  assign take        = burst_valid && burst_ready;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    eff_d   = eff_q;
    align_d = align_q;
    fixed_d = fixed_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    desc_en = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (xfer_start) begin
          if (sel_bad) begin
            err_d = 1'b1;
          end else if (xfer_beats == '0) begin
            done_d = 1'b1;
          end else begin
            st_d    = SEQ_RUN;
            desc_en = 1'b1;
            addr_d  = xfer_addr;
            rem_d   = xfer_beats;
            eff_d   = sel_eff;
            align_d = align_en;
            fixed_d = fixed_burst_en;
          end
        end
      end
      SEQ_RUN: begin
        if (take) begin
          if (burst_last) begin
            st_d   = SEQ_IDLE;
            done_d = 1'b1;
          end else begin
            desc_en = 1'b1;
            addr_d  = addr_q + (ADDR_W'(size) << BEAT_LG);
            rem_d   = rem_q - LEN_W'(size);
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // descriptor registers with explicit load enable
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rem_q   <= '0;
      eff_q   <= '0;
      align_q <= 1'b0;
      fixed_q <= 1'b0;
    end else if (desc_en) begin
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      eff_q   <= eff_d;
      align_q <= align_d;
      fixed_q <= fixed_d;
    end
  end
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int EFF_W = 9,
  parameter int BEAT_LG = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_valid,
  input logic              burst_ready,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [EFF_W-1:0]  burst_beats,
  input logic              burst_last,
  input logic              xfer_done,
  input logic              cfg_err,
  input logic              align_q,
  input logic              fixed_q
);
  localparam logic [EFF_W-1:0] MAX_LEN = EFF_W'(1) << (EFF_W - 1);
  logic [EFF_W-1:0] idx_lo;
  assign idx_lo = burst_addr[EFF_W+BEAT_LG-1:BEAT_LG];

  AST_HOLD_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr)
      && $stable(burst_beats) && $stable(burst_last)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_ready && burst_last |=> xfer_done); // R8
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !burst_valid); // R8
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !burst_valid && !xfer_done); // R3
  AST_BEATS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> burst_beats != '0 && burst_beats <= MAX_LEN); // R2
  AST_FIXED_NATURAL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && align_q && fixed_q |->
      $onehot(burst_beats) && ((idx_lo & (burst_beats - EFF_W'(1))) == '0)); // R6
endmodule

bind dma_burst_seq dma_burst_seq_chk #(.ADDR_W(ADDR_W), .EFF_W(EFF_W), .BEAT_LG(BEAT_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_valid(burst_valid), .burst_ready(burst_ready),
  .burst_addr(burst_addr), .burst_beats(burst_beats), .burst_last(burst_last),
  .xfer_done(xfer_done), .cfg_err(cfg_err), .align_q(align_q), .fixed_q(fixed_q)
);

// File: tb/dma_burst_seq_bench.sv
`timescale 1ns/1ps
module dma_burst_seq_bench;
  logic        clk;
  logic        rst_n;
  logic        xfer_start;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_beats;
  logic        xfer_rx, fixed_burst_en, align_en, split_len_en, len_x8;
  logic [5:0]  tx_len_fld, rx_len_fld;
  logic        burst_valid, burst_ready, burst_last, xfer_done, cfg_err, busy;
  logic [31:0] burst_addr;
  logic [8:0]  burst_beats;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  dma_burst_seq u_dma_burst_seq (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
    .xfer_beats(xfer_beats), .xfer_rx(xfer_rx), .fixed_burst_en(fixed_burst_en),
    .align_en(align_en), .split_len_en(split_len_en), .tx_len_fld(tx_len_fld),
    .rx_len_fld(rx_len_fld), .len_x8(len_x8), .burst_valid(burst_valid),
    .burst_ready(burst_ready), .burst_addr(burst_addr), .burst_beats(burst_beats),
    .burst_last(burst_last), .xfer_done(xfer_done), .cfg_err(cfg_err), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_eff(input bit rx, input bit split, input bit x8,
                                   input int txf, input int rxf);
    int f;
    f = (split && rx) ? rxf : txf;
    if (!(f == 1 || f == 2 || f == 4 || f == 8 || f == 16 || f == 32)) return 0;
    return x8 ? f * 8 : f;
  endfunction

  function automatic int model_len(input longint addr, input int rem, input int eff,
                                   input bit al, input bit fx);
    int l;
    longint idx;
    idx = addr / 4;
    if (!al) return (rem < eff) ? rem : eff;
    if (!fx) begin
      l = eff - int'(idx % eff);
      return (rem < l) ? rem : l;
    end
    l = eff;
    while ((idx % l) != 0 || l > rem) l = l / 2;
    return l;
  endfunction

  // runs one transfer and checks every burst; stall = ready-low cycles per burst
  task automatic run_xfer(input string req, input logic [31:0] addr, input int len,
                          input int stall, input bit poke, input bit scramble);
    int eff, rem, exp;
    longint cur;
    bit al, fx;
    eff = model_eff(xfer_rx, split_len_en, len_x8, tx_len_fld, rx_len_fld);
    al = align_en;
    fx = fixed_burst_en;
    @(negedge clk);
    xfer_start = 1'b1; xfer_addr = addr; xfer_beats = 16'(len);
    @(negedge clk);
    xfer_start = 1'b0;
    if (scramble) begin
      tx_len_fld = 6'd1; rx_len_fld = 6'd1; len_x8 = ~len_x8;
      align_en = ~align_en; fixed_burst_en = ~fixed_burst_en;
    end
    cur = addr; rem = len;
    while (rem > 0) begin
      exp = model_len(cur, rem, eff, al, fx);
      chk(req, "valid", burst_valid, 1);
      chk(req, "addr", burst_addr, cur);
      chk(req, "beats", burst_beats, exp);
      chk(req, "last", burst_last, (exp == rem));
      for (int s = 0; s < stall; s++) begin
        if (poke && s == 0) begin
          xfer_start = 1'b1; xfer_addr = 32'h0000_9000; xfer_beats = 16'd3;
        end
        @(negedge clk);
        xfer_start = 1'b0;
        chk("R7", "held valid", burst_valid, 1);
        chk("R7", "held addr", burst_addr, cur);
        chk("R7", "held beats", burst_beats, exp);
      end
      burst_ready = 1'b1;
      @(negedge clk);
      burst_ready = 1'b0;
      cur = cur + exp * 4;
      rem = rem - exp;
    end
    chk("R8", "done pulse", xfer_done, 1);
    chk("R8", "valid after last", burst_valid, 0);
    @(negedge clk);
    chk("R8", "done one cycle", xfer_done, 0);
    chk("R10", "no ghost transfer", burst_valid, 0);
  endtask

  task automatic set_cfg(input bit rx, input bit split, input int txf, input int rxf,
                         input bit x8, input bit al, input bit fx);
    xfer_rx = rx; split_len_en = split; tx_len_fld = 6'(txf); rx_len_fld = 6'(rxf);
    len_x8 = x8; align_en = al; fixed_burst_en = fx;
  endtask

  task automatic t_reset();
    chk("R12", "valid", burst_valid, 0);
    chk("R12", "done", xfer_done, 0);
    chk("R12", "err", cfg_err, 0);
    chk("R12", "busy", busy, 0);
  endtask

  task automatic t_plain();
    set_cfg(0, 0, 4, 8, 0, 0, 0);
    run_xfer("R4", 32'h1000, 10, 0, 0, 0);          // 4,4,2
    run_xfer("R4", 32'h2004, 7, 1, 0, 0);           // unaligned start, no trim
  endtask

  task automatic t_select();
    set_cfg(1, 1, 2, 8, 0, 0, 0);
    run_xfer("R1", 32'h3000, 20, 0, 0, 0);          // rx field: 8,8,4
    set_cfg(1, 0, 2, 8, 0, 0, 0);
    run_xfer("R1", 32'h3000, 5, 0, 0, 0);           // shared field: 2,2,1
    set_cfg(0, 1, 16, 4, 0, 0, 0);
    run_xfer("R1", 32'h3100, 20, 0, 0, 0);          // tx field: 16,4
  endtask

  task automatic t_x8();
    set_cfg(0, 0, 32, 1, 1, 0, 0);
    run_xfer("R2", 32'h10000, 600, 0, 0, 0);        // 256,256,88
    set_cfg(1, 1, 32, 1, 1, 0, 0);
    run_xfer("R2", 32'h0, 17, 0, 0, 0);             // 8,8,1
  endtask

  task automatic t_trim();
    set_cfg(0, 0, 8, 1, 0, 1, 0);
    run_xfer("R5", 32'h100C, 30, 0, 0, 0);          // 5,8,8,8,1
    run_xfer("R5", 32'h1000, 12, 0, 0, 0);          // aligned start: 8,4
  endtask

  task automatic t_fixed();
    set_cfg(0, 0, 16, 1, 0, 1, 1);
    run_xfer("R6", 32'h0014, 40, 0, 0, 0);          // 1,2,8,16,8,4,1
    set_cfg(1, 1, 1, 4, 1, 1, 1);
    run_xfer("R6", 32'h0104, 70, 0, 0, 0);          // E=32
  endtask

  task automatic t_bad(input int fld);
    set_cfg(0, 0, fld, 1, 0, 0, 0);
    @(negedge clk);
    xfer_start = 1'b1; xfer_addr = 32'h500; xfer_beats = 16'd8;
    @(negedge clk);
    xfer_start = 1'b0;
    chk("R3", "err pulse", cfg_err, 1);
    chk("R3", "no burst", burst_valid, 0);
    @(negedge clk);
    chk("R3", "err one cycle", cfg_err, 0);
    chk("R3", "no burst later", burst_valid, 0);
    chk("R3", "no done", xfer_done, 0);
  endtask

  task automatic t_zero();
    set_cfg(0, 0, 4, 1, 0, 0, 0);
    @(negedge clk);
    xfer_start = 1'b1; xfer_addr = 32'h600; xfer_beats = 16'd0;
    @(negedge clk);
    xfer_start = 1'b0;
    chk("R9", "done pulse", xfer_done, 1);
    chk("R9", "no burst", burst_valid, 0);
    @(negedge clk);
    chk("R9", "done one cycle", xfer_done, 0);
    chk("R9", "still idle", busy, 0);
  endtask

  task automatic t_busy_and_latch();
    set_cfg(0, 0, 4, 1, 0, 0, 0);
    run_xfer("R10", 32'h7000, 9, 2, 1, 0);          // restart while busy ignored
    set_cfg(0, 0, 8, 1, 0, 1, 0);
    run_xfer("R11", 32'h7004, 20, 0, 0, 1);         // config changed after start
  endtask

  initial begin
    rst_n = 1'b0; xfer_start = 1'b0; xfer_addr = '0; xfer_beats = '0;
    burst_ready = 1'b0;
    set_cfg(0, 0, 1, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_select();
    t_x8();
    t_trim();
    t_fixed();
    t_bad(3);
    t_bad(0);
    t_zero();
    t_busy_and_latch();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule